// File: doc/BRIEF.md
# Infrared Remote Transmit Buffer with Flow Control

This block sits between a host UART and the infrared output of a remote-control transmitter. It watches the UART transmit line, recovers each 8-bit character and discards the start and stop bits. The data bits are queued and then sent out as one unbroken serial stream at a fixed slow rate, typically about 2400 bps. Characters from the host may keep arriving while earlier ones are still going out. Carrier modulation and LED drive belong to later stages.

The buffer holds up to 22 characters, counting the one being sent. Data flows in over a plain serial line, so back-pressure is a level signal. `busy` goes high once 21 characters are held. A host that waits for `busy` to fall before starting its next character never loses data. `busy` falls only when a character has finished leaving the output, which brings the count down to 20. A character that arrives when all 22 slots are taken is dropped, and `overflow` is set and stays set. The output side carries `ir_valid` beside `ir_data`: `ir_valid` is high for every bit period in which a data bit is on the line. The output has no ready input because the stream cannot be stalled.

`rx_div` sets the number of clocks per sixteenth of an input bit. `bit_div` sets the number of clocks per output bit. For 2400 bps this is the clock frequency divided by 2400.

Top module: `ir_tx_buffer`

## Requirements
- R1: The receiver samples `txd` at 16 ticks per bit and confirms a start bit 8 ticks after the falling edge. A low pulse shorter than half a bit starts no character.
- R2: Each character is 1 start bit (0), 8 data bits with the LSB first, and 1 stop bit (1). Only the 8 data bits appear on `ir_data`, again LSB first.
- R3: A character whose stop bit samples low is discarded. The receiver then waits for `txd` to return high before it looks for a new start bit.
- R4: Each output bit lasts `bit_div` clocks. `ir_valid` is high during every output bit period.
- R5: When another character is held, bit 0 of that character follows bit 7 of the previous character on the next clock, with no idle gap.
- R6: Up to 22 characters, including the one being sent, are held. They leave in arrival order.
- R7: `busy` is high whenever 21 or more characters are held, and it rises only when a character is accepted.
- R8: `busy` falls only when a character finishes transmission, that is, when the held count drops from 21 to 20.
- R9: A character completed while 22 are held is dropped. `overflow` then goes high and stays high until reset.
- R10: When nothing is held, `ir_valid` and `ir_data` are both low.
- R11: After reset, `busy`, `overflow`, `ir_valid` and `ir_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txd | input | 1 | Asynchronous UART line from the host, idle high |
| rx_div | input | 16 | Clocks per input oversample tick (1/16 bit) |
| bit_div | input | 16 | Clocks per output bit |
| busy | output | 1 | Host must not start a new character while high |
| overflow | output | 1 | Sticky: a character was dropped because the buffer was full |
| ir_valid | output | 1 | A data bit is being driven on `ir_data` |
| ir_data | output | 1 | Serialized data bits, LSB first, low when idle |

## Verification
The bench fills the buffer while the output is held nearly still, then counts the exact character that raises `busy` and the exact one that is dropped. A design that is off by one on either threshold flags too early, flags too late, or loses a character. During the drain it checks that `busy` holds through the first completion and falls after the second. A design that releases `busy` when a character is loaded, rather than when it finishes, fails that check. A long run with the host honouring `busy` checks every output bit at mid-period and requires `ir_valid` to stay high across character boundaries. A serializer that idles for even one bit period between characters would show a gap, and a wrong bit order would miscompare. Short low glitches and characters with a low stop bit must leave the output idle. A receiver that skips the mid-bit start check, or re-arms on the low stop bit, would emit a phantom character.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

endpackage

// File: rtl/ir_baud_tick.sv
module ir_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  // a divide value of zero behaves like one: tick every clock
  assign tick = (cnt_next >= {1'b0, div});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_next[DIV_W-1:0];
    end
  end

endmodule

// File: rtl/ir_uart_rx.sv
module ir_uart_rx
  import ir_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_async,
  input  logic [DIV_W-1:0]  div,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data
);

  localparam int OS_W  = $clog2(OS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OS - 1);
  localparam logic [OS_W-1:0]  OS_HALF  = OS_W'(OS / 2 - 1);
  localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(DATA_W - 1);

  // metastability chain on the asynchronous line, idle level is high
  logic [SYNC_STAGES-1:0] sync_q;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[gi] <= 1'b1;
          else        sync_q[gi] <= rxd_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[gi] <= 1'b1;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  logic rxd;
  assign rxd = sync_q[SYNC_STAGES-1];

  logic tick;
  ir_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (div),
    .tick (tick)
  );

  rx_state_e         state;
  logic [OS_W-1:0]   os_cnt;
  logic [IDX_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      os_cnt     <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      char_valid <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state  <= RX_START;
              os_cnt <= '0;
            end
          end
          RX_START: begin
            if (os_cnt == OS_HALF) begin
              os_cnt  <= '0;
              bit_cnt <= '0;
              state   <= rxd ? RX_IDLE : RX_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (os_cnt == OS_LAST) begin
              os_cnt <= '0;
              shreg  <= {rxd, shreg[DATA_W-1:1]};
              if (bit_cnt == BIT_LAST) state <= RX_STOP;
              else                     bit_cnt <= bit_cnt + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (os_cnt == OS_LAST) begin
              os_cnt <= '0;
              if (rxd) begin
                char_valid <= 1'b1;
                state      <= RX_IDLE;
              end else begin
                state <= RX_BREAK;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          RX_BREAK: begin
            if (rxd) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign char_data = shreg;

endmodule

// File: rtl/ir_char_fifo.sv
module ir_char_fifo #(
  parameter int W = 8,
  parameter int N = 21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           push_data,
  input  logic                   pop,
  output logic [W-1:0]           head,
  output logic [$clog2(N+1)-1:0] count,
  output logic                   empty,
  output logic                   full
);

  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam int CNT_W = $clog2(N + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N);

  logic [W-1:0]     mem [N];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             do_push;
  logic             do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ir_bit_serializer.sv
module ir_bit_serializer #(
  parameter int W     = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             src_valid,
  input  logic [W-1:0]     src_data,
  output logic             src_pop,
  output logic             ser_active,
  output logic             ser_bit,
  output logic             char_done
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

  logic [W-1:0]     shreg;
  logic [IDX_W-1:0] idx;
  logic [DIV_W-1:0] tcnt;
  logic [DIV_W:0]   tcnt_next;
  logic             bit_end;

  assign tcnt_next = {1'b0, tcnt} + 1'b1;
  // >= so a smaller divide value written mid-bit ends the bit at once
  assign bit_end   = ser_active && (tcnt_next >= {1'b0, div});
  assign char_done = bit_end && (idx == IDX_LAST);
  assign src_pop   = src_valid && (!ser_active || char_done);
  assign ser_bit   = ser_active && shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_active <= 1'b0;
      shreg      <= '0;
      idx        <= '0;
      tcnt       <= '0;
    end else if (!ser_active) begin
      tcnt <= '0;
      if (src_valid) begin
        shreg      <= src_data;
        idx        <= '0;
        ser_active <= 1'b1;
      end
    end else if (bit_end) begin
      tcnt <= '0;
      if (idx == IDX_LAST) begin
        if (src_valid) begin
          shreg <= src_data;
          idx   <= '0;
        end else begin
          ser_active <= 1'b0;
          shreg      <= '0;
        end
      end else begin
        shreg <= shreg >> 1;
        idx   <= idx + 1'b1;
      end
    end else begin
      tcnt <= tcnt_next[DIV_W-1:0];
    end
  end

endmodule

// File: rtl/ir_tx_buffer.sv
module ir_tx_buffer
  import ir_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 22,
  parameter int OS     = 16,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txd,
  input  logic [DIV_W-1:0] rx_div,
  input  logic [DIV_W-1:0] bit_div,
  output logic             busy,
  output logic             overflow,
  output logic             ir_valid,
  output logic             ir_data
);

  // one slot lives in the serializer, the rest in the queue
  localparam int FIFO_N = DEPTH - 1;
  localparam int CNT_W  = $clog2(FIFO_N + 1);
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] OCC_WARN = OCC_W'(DEPTH - 1);

  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic              accept;
  logic              fifo_pop;
  logic [DATA_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty;
  logic              fifo_full;
  logic              ser_active;
  logic              ser_bit;
  logic              char_done;
  logic [OCC_W-1:0]  occ;

  ir_uart_rx #(
    .DATA_W(DATA_W),
    .OS    (OS),
    .DIV_W (DIV_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd_async (txd),
    .div       (rx_div),
    .char_valid(rx_valid),
    .char_data (rx_data)
  );

  assign occ    = OCC_W'(fifo_cnt) + OCC_W'(ser_active);
  assign accept = rx_valid && (occ < OCC_FULL) && !fifo_full;

  ir_char_fifo #(
    .W(DATA_W),
    .N(FIFO_N)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_data(rx_data),
    .pop      (fifo_pop),
    .head     (fifo_head),
    .count    (fifo_cnt),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  ir_bit_serializer #(
    .W    (DATA_W),
    .DIV_W(DIV_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (bit_div),
    .src_valid (!fifo_empty),
    .src_data  (fifo_head),
    .src_pop   (fifo_pop),
    .ser_active(ser_active),
    .ser_bit   (ser_bit),
    .char_done (char_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   overflow <= 1'b0;
    else if (rx_valid && !accept) overflow <= 1'b1;
  end

  assign busy     = (occ >= OCC_WARN);
  assign ir_valid = ser_active;
  assign ir_data  = ser_bit;

endmodule

// File: rtl/ir_tx_buffer_chk.sv
module ir_tx_buffer_chk #(
  parameter int DEPTH = 22
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         overflow,
  input logic                         ir_valid,
  input logic                         ir_data,
  input logic [$clog2(DEPTH+1)-1:0]   occ,
  input logic                         rx_valid,
  input logic                         char_done
);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_valid |-> !ir_data);

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_valid));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(char_done));

  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && occ > 1) |=> ir_valid);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(rx_valid));

endmodule

bind ir_tx_buffer ir_tx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .overflow (overflow),
  .ir_valid (ir_valid),
  .ir_data  (ir_data),
  .occ      (occ),
  .rx_valid (rx_valid),
  .char_done(char_done)
);

// File: tb/sim_ir_tx_buffer.sv
`timescale 1ns/1ps
module sim_ir_tx_buffer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txd = 1'b1;
  logic [15:0] rx_div = 16'd2;
  logic [15:0] bit_div = 16'd200;
  logic        busy;
  logic        overflow;
  logic        ir_valid;
  logic        ir_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ir_tx_buffer u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .rx_div  (rx_div),
    .bit_div (bit_div),
    .busy    (busy),
    .overflow(overflow),
    .ir_valid(ir_valid),
    .ir_data (ir_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int set, input int i);
    if (set == 1) begin
      if (i == 0) return 8'h00;
      if (i == 1) return 8'hFF;
      return 8'((i * 73 + 17) ^ (i << 4));
    end
    return 8'(i * 29 + 3);
  endfunction

  // one UART character, 16*rx_div clocks per bit
  task automatic send_char(input logic [7:0] d, input bit stop);
    int per;
    per = 16 * int'(rx_div);
    @(negedge clk);
    txd = 1'b0;
    repeat (per) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      txd = d[b];
      repeat (per) @(negedge clk);
    end
    txd = stop;
    repeat (per) @(negedge clk);
    txd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    txd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // samples every output bit at mid-period; fb is the first bit index of char 0
  task automatic collect(input int n, input int fb, input int set, input bit busy_chk);
    int per;
    bit first;
    logic [7:0] got;
    logic [7:0] mask;
    per = int'(bit_div);
    first = 1'b1;
    if (fb == 0) begin
      do @(negedge clk); while (!ir_valid);
      repeat (per / 2 - 1) @(negedge clk);
    end else begin
      repeat (per / 2) @(negedge clk);
    end
    for (int c = 0; c < n; c++) begin
      got = 8'h00;
      for (int b = ((c == 0) ? fb : 0); b < 8; b++) begin
        if (!first) repeat (per) @(negedge clk);
        first = 1'b0;
        got[b] = ir_data;
        if (b == 0 || b == 7)
          check(ir_valid === 1'b1, "R5 R4 gapless valid", int'(ir_valid), 1);
        if (busy_chk && b == 0 && c == 1)
          check(busy === 1'b1, "R8 busy held at 21", int'(busy), 1);
        if (busy_chk && b == 0 && c == 2)
          check(busy === 1'b0, "R8 busy released at 20", int'(busy), 0);
      end
      mask = (c == 0 && fb == 1) ? 8'hFE : 8'hFF;
      check((got & mask) === (pat(set, c) & mask), "R2 R6 char data/order",
            int'(got & mask), int'(pat(set, c) & mask));
    end
    repeat (per / 2 + 2) @(negedge clk);
    check(ir_valid === 1'b0 && ir_data === 1'b0, "R10 idle after drain",
          int'({ir_valid, ir_data}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check(busy === 1'b0 && overflow === 1'b0, "R11 reset flags",
          int'({busy, overflow}), 0);
    check(ir_valid === 1'b0 && ir_data === 1'b0, "R11 reset output",
          int'({ir_valid, ir_data}), 0);

    // R1: low glitch of 4 clocks, much shorter than half a 32-clock bit
    rx_div = 16'd2;
    bit_div = 16'd200;
    @(negedge clk);
    txd = 1'b0;
    repeat (4) @(negedge clk);
    txd = 1'b1;
    repeat (600) @(negedge clk);
    check(ir_valid === 1'b0, "R1 glitch ignored", int'(ir_valid), 0);

    // R3: stop bit low drops the character
    send_char(8'h3C, 1'b0);
    repeat (600) @(negedge clk);
    check(ir_valid === 1'b0 && overflow === 1'b0, "R3 framing error dropped",
          int'({ir_valid, overflow}), 0);

    // main run: host honours busy, stream must stay gapless and in order
    fork
      begin
        for (int i = 0; i < 30; i++) begin
          while (busy) @(negedge clk);
          send_char(pat(1, i), 1'b1);
        end
      end
      collect(30, 0, 1, 1'b0);
    join
    check(overflow === 1'b0, "R9 no overflow when busy honoured", int'(overflow), 0);

    // fill test: output almost frozen
    do_reset();
    rx_div = 16'd1;
    bit_div = 16'd10000;
    @(negedge clk);
    for (int i = 0; i < 23; i++) begin
      send_char(pat(2, i), 1'b1);
      if (i == 19)
        check(busy === 1'b0, "R7 busy low at 20 held", int'(busy), 0);
      if (i == 20)
        check(busy === 1'b1 && overflow === 1'b0, "R7 busy high at 21 held",
              int'({busy, overflow}), 2);
      if (i == 21)
        check(busy === 1'b1 && overflow === 1'b0, "R9 22nd char accepted",
              int'({busy, overflow}), 2);
      if (i == 22)
        check(overflow === 1'b1, "R9 23rd char dropped", int'(overflow), 1);
    end
    // speed output up: current (first) bit ends on the next clock
    bit_div = 16'd200;
    collect(22, 1, 2, 1'b1);
    check(overflow === 1'b1, "R9 overflow sticky", int'(overflow), 1);
    check(busy === 1'b0, "R7 busy low when empty", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule